// File: doc/BRIEF.md
# Transmit Echo Consistency Checker

On a single-wire bus, everything a node transmits also appears on its own receive line. This block sits beside a UART transmitter and its receiver. Each time the receiver finishes assembling a byte, the block compares that byte with the byte the transmitter just sent.

If checking is enabled and the two bytes differ, another driver or a fault has disturbed the bus. The block then does three things:
- it latches a sticky error flag;
- it raises a one-cycle interrupt pulse;
- it asserts a transmit-inhibit output, so the transmitter does not start its next byte.

Software reads the flag and writes a one to the clear input. That drops the flag and releases the inhibit. The serializer, the deserializer and baud timing lie outside this block.

Top module: `echo_chk`

## Requirements
- R1: After a synchronous reset, `err_flag`, `err_irq` and `tx_hold` are all 0.
- R2: When `rx_done`=1 and `chk_en`=1 in a cycle where `tx_byte` differs from `rx_byte` in any bit, `err_flag` is 1 from the next cycle on.
- R3: `err_irq` is 1 for exactly one cycle for each detected mismatch. It is high in the same cycle in which the flag first shows the mismatch, and `err_irq`=1 always coincides with `err_flag`=1.
- R4: With `chk_en`=0, a completed byte never sets `err_flag` and never pulses `err_irq`, whatever the data.
- R5: A completed byte whose echo matches bit for bit causes no interrupt and leaves `err_flag` at its previous value (0 stays 0, 1 stays 1).
- R6: Once set, `err_flag` remains 1 until a clear is requested.
- R7: `clr_err`=1 in a cycle with no new mismatch makes `err_flag` 0 in the next cycle. `clr_err`=0 has no effect.
- R8: If `clr_err`=1 and a new mismatch occur in the same cycle, the mismatch wins: the flag is 1 in the next cycle and `err_irq` pulses.
- R9: `tx_hold` equals `err_flag` in every cycle, so transfers are blocked exactly while the error is outstanding.
- R10: Without `rx_done`, differing bytes have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_byte | input | DATA_W | Byte most recently sent by the transmitter |
| rx_byte | input | DATA_W | Byte assembled from the bus echo |
| rx_done | input | 1 | One-cycle strobe: echoed byte complete |
| chk_en | input | 1 | 1 enables the echo comparison |
| clr_err | input | 1 | Write-one-to-clear for the error flag |
| err_flag | output | 1 | Sticky consistency-error flag |
| err_irq | output | 1 | One-cycle status interrupt pulse |
| tx_hold | output | 1 | 1 blocks the next transmit transfer |

## Verification
The bench drives matched byte pairs, which must pass silently, and mismatched pairs that differ in the top bit, in the bottom bit or in every bit, so that no bit position escapes the compare. The same mismatch is also applied with the enable low or without the completion strobe, which isolates the gating conditions from the compare itself. Clear requests are applied alone and together with a fresh mismatch, which separates plain clearing from the mismatch-wins priority. Repeated mismatches while the flag is already set confirm that every detection pulses the interrupt again.

// File: rtl/echo_chk_pkg.sv
package echo_chk_pkg;
  // Command presented to the sticky flag stage each cycle
  typedef struct packed {
    logic miss;   // qualified mismatch event
    logic clr;    // write-one-to-clear request
  } flag_cmd_t;
endpackage

// File: rtl/echo_cmp.sv
module echo_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] sent,
  input  logic [DATA_W-1:0] heard,
  input  logic              done,
  input  logic              enable,
  output logic              miss
);
  logic [DATA_W-1:0] bit_diff;

  // One XOR per bit lane
  for (genvar b = 0; b < DATA_W; b++) begin : g_lane
    assign bit_diff[b] = sent[b] ^ heard[b];
  end

  assign miss = done & enable & (|bit_diff);
endmodule

// File: rtl/echo_flag.sv
module echo_flag
  import echo_chk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_cmd_t cmd,
  output logic      flag_q,
  output logic      irq_q,
  output logic      hold_q
);
  logic flag_d;

  // A new mismatch takes priority over a clear request
  always_comb begin
    flag_d = flag_q;
    if (cmd.clr)  flag_d = 1'b0;
    if (cmd.miss) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= cmd.miss;
    end
  end

  // Separate register for the inhibit so it can be placed near the transmitter
  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= flag_d;
  end

  p_set_on_miss_r2: assert property (@(posedge clk) disable iff (rst)
    cmd.miss |=> (flag_q && irq_q));
  p_irq_with_flag_r3: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q);
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !cmd.clr) |=> flag_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd.clr && !cmd.miss) |=> !flag_q);
  p_miss_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd.clr && cmd.miss) |=> (flag_q && irq_q));
  p_no_irq_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !cmd.miss |=> !irq_q);
endmodule

// File: rtl/echo_chk.sv
module echo_chk
  import echo_chk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_done,
  input  logic              chk_en,
  input  logic              clr_err,
  output logic              err_flag,
  output logic              err_irq,
  output logic              tx_hold
);
  logic      miss;
  flag_cmd_t cmd;

  echo_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sent   (tx_byte),
    .heard  (rx_byte),
    .done   (rx_done),
    .enable (chk_en),
    .miss   (miss)
  );

  assign cmd.miss = miss;
  assign cmd.clr  = clr_err;

  echo_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .flag_q (err_flag),
    .irq_q  (err_irq),
    .hold_q (tx_hold)
  );

  p_hold_tracks_flag_r9: assert property (@(posedge clk) disable iff (rst)
    tx_hold == err_flag);
  p_gate_off_r4: assert property (@(posedge clk) disable iff (rst)
    !chk_en |=> !err_irq);
  p_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    (!rx_done && !clr_err) |=> $stable(err_flag));
endmodule

// File: tb/echo_chk_tb_top.sv
module echo_chk_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] tx_byte, rx_byte;
  logic       rx_done, chk_en, clr_err;
  logic       err_flag, err_irq, tx_hold;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         timed_out = 1'b0;

  always #10 clk = ~clk;

  echo_chk #(.DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .tx_byte(tx_byte), .rx_byte(rx_byte),
    .rx_done(rx_done), .chk_en(chk_en), .clr_err(clr_err),
    .err_flag(err_flag), .err_irq(err_irq), .tx_hold(tx_hold)
  );

  // Vector: tx, rx, done, en, clr, expected flag, expected irq
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {8'hA5, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hA5, 8'hA4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hA5, 8'hA4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hA5, 8'hA4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h3C, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h80, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h01, 8'h01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'hFF, 8'hFE, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h7F, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R5";  1: return "R4";  2: return "R10"; 3: return "R2";
      4: return "R6";  5: return "R5";  6: return "R4";  7: return "R7";
      8: return "R8";  9: return "R5";  10: return "R7"; 11: return "R2";
      12: return "R3"; default: return "R7";
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tx_byte = '0; rx_byte = '0; rx_done = 0; chk_en = 0; clr_err = 0;
  endtask

  initial begin
    #2_000_000;
    timed_out = 1'b1;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    check(err_flag, 1'b0, "R1 flag after reset");
    check(err_irq,  1'b0, "R1 irq after reset");
    check(tx_hold,  1'b0, "R1 hold after reset");

    for (int i = 0; i < NV; i++) begin
      {tx_byte, rx_byte, rx_done, chk_en, clr_err} = VEC[i][20:2];
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
      check(err_flag, VEC[i][1], $sformatf("%s vec %0d flag", tag_of(i), i));
      check(err_irq,  VEC[i][0], $sformatf("%s vec %0d irq", tag_of(i), i));
      check(tx_hold,  VEC[i][1], $sformatf("R9 vec %0d hold", i));
    end

    // R3: pulse lasts one cycle while flag stays
    tx_byte = 8'h55; rx_byte = 8'hAA; rx_done = 1; chk_en = 1;
    @(posedge clk); @(negedge clk); idle_inputs();
    check(err_irq, 1'b1, "R3 pulse high");
    @(posedge clk); @(negedge clk);
    check(err_irq,  1'b0, "R3 pulse single cycle");
    check(err_flag, 1'b1, "R6 flag held");
    check(tx_hold,  1'b1, "R9 hold held");

    // R1: reset clears a pending error
    rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    check(err_flag, 1'b0, "R1 flag after mid reset");
    check(tx_hold,  1'b0, "R1 hold after mid reset");

    if (!timed_out) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule